// File: doc/BRIEF.md
# Flash Block Erase and Verify Sequencer

This controller erases a flash array one block at a time and then confirms the result. A single start command carries a mask of the blocks to clear. The controller takes the set blocks in ascending index order. For each block it raises the array's control strobes in a fixed, interlocked order: write enable, block select together with watchdog arming, erase setup, and the erase pulse itself. Every gap between strobe edges has a minimum length, and each of these lengths is supplied as a cycle count on an input. The erase pulse length is also an input, but a build-time ceiling clips it so that an over-long pulse can never reach the array.

After each erase pulse the strobes drop in reverse order, the watchdog is released and the controller enters verify mode. For every word of the block it issues a dummy write of all ones and then a verify read from the same address. When a word reads back as not fully erased, the block gets another erase pulse and verification starts again from the first word. Each block is allowed a bounded number of pulses. A block that uses up its pulses stops the run with a fail flag and the index of the offending block. When the run ends, by success or by failure, the controller leaves verify mode, drops write enable and holds done or fail until the next accepted start.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is low and after it is released, every strobe (`swe_o`, `blk_sel_o`, `esu_o`, `ers_o`, `ev_o`, `wdt_arm_o`, `flash_we_o`, `flash_re_o`) is low, and `busy_o`, `done_o` and `fail_o` are low.
- R2: A start with a nonzero mask is accepted only while `busy_o` is low. `busy_o` is high in the cycle after acceptance and falls only together with `done_o` or `fail_o` rising. A start that arrives while busy changes neither the blocks erased nor the outcome.
- R3: Write enable rises first. The block select and the watchdog arm follow at least `t_swe_i` cycles later. Erase setup rises after that, and the erase strobe rises at least `t_esu_i` cycles after erase setup. The erase strobe is high only while erase setup, write enable and watchdog arm are all high.
- R4: The erase strobe stays high for exactly max(min(`t_erase_i`, ERS_MAX), 1) cycles and is never high longer than ERS_MAX cycles.
- R5: After a pulse, the erase strobe falls first. Erase setup falls at least `t_esu_off_i` cycles later. The watchdog arm falls at least `t_wdt_clr_i` cycles after erase setup, in the same cycle that verify mode (`ev_o`) rises.
- R6: In verify mode each word, taken from address 0 upward, gets a one-cycle dummy write with `flash_wdata_o` = 16'hFFFF, followed by a one-cycle read at the same address. The first dummy write comes at least `t_ev_on_i` cycles after `ev_o` rises. Each read comes at least `t_rd_i` cycles after its dummy write. Dummy writes and reads happen only while `ev_o` is high and `esu_o` is low.
- R7: A read value of 16'hFFFF advances to the next address. Any other value drops `ev_o` and gives the same block another erase pulse, after which verification restarts at address 0.
- R8: A block receives at most `max_tries_i` erase pulses. When the last allowed pulse still fails verification, the run ends with `fail_o` high and `fail_blk_o` equal to that block's index, and no later block is touched.
- R9: Blocks are handled one at a time in ascending index order, and only blocks set in the mask are handled. `blk_sel_o` is one-hot or zero.
- R10: At the end of a run `ev_o` falls, `swe_o` falls at least `t_ev_off_i` cycles later, and `done_o` (success) or `fail_o` rises at least `t_swe_off_i` cycles after that. The flag then stays high until the next accepted start, which clears it.
- R11: A start with an all-zero mask is ignored: `busy_o` stays low and the previous `done_o` or `fail_o` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request |
| blk_mask_i | input | NBLK | Blocks to erase, one bit per block |
| t_swe_i | input | CNT_W | Minimum cycles from write enable to block select |
| t_esu_i | input | CNT_W | Minimum cycles from erase setup to erase pulse |
| t_erase_i | input | CNT_W | Requested erase pulse length |
| t_esu_off_i | input | CNT_W | Minimum cycles from erase fall to setup fall |
| t_wdt_clr_i | input | CNT_W | Minimum cycles from setup fall to watchdog release |
| t_ev_on_i | input | CNT_W | Minimum cycles from verify entry to first dummy write |
| t_rd_i | input | CNT_W | Minimum cycles from dummy write to verify read |
| t_ev_off_i | input | CNT_W | Minimum cycles from verify exit to write enable fall |
| t_swe_off_i | input | CNT_W | Minimum cycles from write enable fall to done or fail |
| max_tries_i | input | TRY_W | Maximum erase pulses per block |
| flash_rdata_i | input | DATA_W | Verify read data from the array |
| swe_o | output | 1 | Software write enable strobe |
| blk_sel_o | output | NBLK | One-hot block select |
| esu_o | output | 1 | Erase setup strobe |
| ers_o | output | 1 | Erase strobe |
| ev_o | output | 1 | Erase verify mode strobe |
| wdt_arm_o | output | 1 | Watchdog armed during erase |
| flash_we_o | output | 1 | Dummy write strobe |
| flash_re_o | output | 1 | Verify read strobe |
| flash_addr_o | output | ADDR_W | Word address within the block |
| flash_wdata_o | output | DATA_W | Dummy write data, all ones |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run succeeded |
| fail_o | output | 1 | Last run failed |
| fail_blk_o | output | BLK_W | Index of the block that failed |

## Verification
A wrong state shows directly at the ports, because every strobe is decoded from the state. A missing or reordered step becomes a strobe edge that is out of sequence, or a gap between edges that is too short. The bench's edge monitor sees such a fault in the cycle it happens. Faults in the address counter or the retry counter take longer to show: a verify read at an unexpected address, the wrong number of erase pulses on a block, or a wrong outcome and failing index once the run ends. The bench pairs each read address with its dummy write and counts pulses per block against a model array. A pulse-length fault is caught at the falling edge of the erase strobe.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_SWE_ON,
        S_SEL,
        S_ESU_ON,
        S_ERASE,
        S_ERS_OFF,
        S_ESU_OFF,
        S_EV_ON,
        S_DWR,
        S_RDW,
        S_RD,
        S_EV_OFF,
        S_SWE_OFF
    } fe_state_e;
endpackage

// File: rtl/flash_erase_pick.sv
// Lowest-index pending block selector.
module flash_erase_pick #(
    parameter int NBLK  = 4,
    parameter int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic [NBLK-1:0]  mask_i,
    output logic [BLK_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = BLK_W'(i);
        end
    end
    assign any_o = |mask_i;
endmodule

// File: rtl/flash_erase_tmr.sv
// Shared wait counter: a load of W makes expire_o rise after max(W,1) cycles.
module flash_erase_tmr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)          cnt_d = val_i;
        else if (cnt_q > 1)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q <= 1);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int NBLK    = 4,
    parameter int ADDR_W  = 3,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16,
    parameter int TRY_W   = 4,
    parameter int ERS_MAX = 4000,
    localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NBLK-1:0]   blk_mask_i,
    input  logic [CNT_W-1:0]  t_swe_i,
    input  logic [CNT_W-1:0]  t_esu_i,
    input  logic [CNT_W-1:0]  t_erase_i,
    input  logic [CNT_W-1:0]  t_esu_off_i,
    input  logic [CNT_W-1:0]  t_wdt_clr_i,
    input  logic [CNT_W-1:0]  t_ev_on_i,
    input  logic [CNT_W-1:0]  t_rd_i,
    input  logic [CNT_W-1:0]  t_ev_off_i,
    input  logic [CNT_W-1:0]  t_swe_off_i,
    input  logic [TRY_W-1:0]  max_tries_i,
    input  logic [DATA_W-1:0] flash_rdata_i,
    output logic              swe_o,
    output logic [NBLK-1:0]   blk_sel_o,
    output logic              esu_o,
    output logic              ers_o,
    output logic              ev_o,
    output logic              wdt_arm_o,
    output logic              flash_we_o,
    output logic              flash_re_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    output logic [DATA_W-1:0] flash_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [BLK_W-1:0]  fail_blk_o
);
    localparam logic [CNT_W-1:0] ERS_CAP = CNT_W'(ERS_MAX);

    typedef struct packed {
        fe_state_e         st;
        logic [NBLK-1:0]   rem;
        logic [BLK_W-1:0]  blk;
        logic [ADDR_W-1:0] addr;
        logic [TRY_W-1:0]  tries;
        logic              done;
        logic              fail;
        logic [BLK_W-1:0]  fail_blk;
    } seq_t;

    seq_t r_d, r_q;
    logic             ld;
    logic [CNT_W-1:0] ldv;
    logic             expire;
    logic [BLK_W-1:0] pick_idx;
    logic             pick_any;
    logic [CNT_W-1:0] ers_len;
    logic             word_ok;

    flash_erase_pick #(.NBLK(NBLK), .BLK_W(BLK_W)) pick_i (
        .mask_i (r_q.rem),
        .idx_o  (pick_idx),
        .any_o  (pick_any)
    );

    flash_erase_tmr #(.CNT_W(CNT_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ld),
        .val_i    (ldv),
        .expire_o (expire)
    );

    assign ers_len = (t_erase_i > ERS_CAP) ? ERS_CAP : t_erase_i;
    assign word_ok = &flash_rdata_i;

    always_comb begin
        r_d = r_q;
        ld  = 1'b0;
        ldv = '0;
        unique case (r_q.st)
            S_IDLE: if (start_i && |blk_mask_i) begin
                r_d.st = S_SWE_ON; r_d.rem = blk_mask_i;
                r_d.done = 1'b0; r_d.fail = 1'b0; r_d.fail_blk = '0;
                ld = 1'b1; ldv = t_swe_i;
            end
            S_SWE_ON: if (expire) begin
                r_d.st = S_SEL; r_d.blk = pick_idx; r_d.tries = '0;
                ld = 1'b1;
            end
            S_SEL: begin
                r_d.st = S_ESU_ON; r_d.addr = '0;
                ld = 1'b1; ldv = t_esu_i;
            end
            S_ESU_ON: if (expire) begin
                r_d.st = S_ERASE;
                if (r_q.tries != '1) r_d.tries = r_q.tries + 1'b1;
                ld = 1'b1; ldv = ers_len;
            end
            S_ERASE: if (expire) begin
                r_d.st = S_ERS_OFF; ld = 1'b1; ldv = t_esu_off_i;
            end
            S_ERS_OFF: if (expire) begin
                r_d.st = S_ESU_OFF; ld = 1'b1; ldv = t_wdt_clr_i;
            end
            S_ESU_OFF: if (expire) begin
                r_d.st = S_EV_ON; r_d.addr = '0; ld = 1'b1; ldv = t_ev_on_i;
            end
            S_EV_ON: if (expire) begin
                r_d.st = S_DWR; ld = 1'b1;
            end
            S_DWR: begin
                r_d.st = S_RDW; ld = 1'b1; ldv = t_rd_i;
            end
            S_RDW: if (expire) begin
                r_d.st = S_RD; ld = 1'b1;
            end
            S_RD: begin
                ld = 1'b1;
                if (word_ok) begin
                    if (&r_q.addr) begin
                        r_d.st = S_EV_OFF; r_d.rem[r_q.blk] = 1'b0;
                        ldv = t_ev_off_i;
                    end else begin
                        r_d.st = S_DWR; r_d.addr = r_q.addr + 1'b1;
                    end
                end else if (r_q.tries >= max_tries_i) begin
                    r_d.st = S_EV_OFF; r_d.fail = 1'b1; r_d.fail_blk = r_q.blk;
                    ldv = t_ev_off_i;
                end else begin
                    r_d.st = S_SEL;
                end
            end
            S_EV_OFF: if (expire) begin
                ld = 1'b1;
                if (!r_q.fail && pick_any) begin
                    r_d.st = S_SEL; r_d.blk = pick_idx; r_d.tries = '0;
                end else begin
                    r_d.st = S_SWE_OFF; ldv = t_swe_off_i;
                end
            end
            S_SWE_OFF: if (expire) begin
                r_d.st = S_IDLE;
                if (!r_q.fail) r_d.done = 1'b1;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= S_IDLE;
            r_q.rem      <= '0;
            r_q.blk      <= '0;
            r_q.addr     <= '0;
            r_q.tries    <= '0;
            r_q.done     <= 1'b0;
            r_q.fail     <= 1'b0;
            r_q.fail_blk <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    logic in_blk;
    assign in_blk = (r_q.st inside {S_SEL, S_ESU_ON, S_ERASE, S_ERS_OFF, S_ESU_OFF,
                                    S_EV_ON, S_DWR, S_RDW, S_RD, S_EV_OFF});

    assign swe_o         = (r_q.st != S_IDLE) && (r_q.st != S_SWE_OFF);
    assign blk_sel_o     = in_blk ? (NBLK'(1) << r_q.blk) : '0;
    assign wdt_arm_o     = (r_q.st inside {S_SEL, S_ESU_ON, S_ERASE, S_ERS_OFF, S_ESU_OFF});
    assign esu_o         = (r_q.st inside {S_ESU_ON, S_ERASE, S_ERS_OFF});
    assign ers_o         = (r_q.st == S_ERASE);
    assign ev_o          = (r_q.st inside {S_EV_ON, S_DWR, S_RDW, S_RD});
    assign flash_we_o    = (r_q.st == S_DWR);
    assign flash_re_o    = (r_q.st == S_RD);
    assign flash_addr_o  = r_q.addr;
    assign flash_wdata_o = '1;
    assign busy_o        = (r_q.st != S_IDLE);
    assign done_o        = r_q.done && (r_q.st == S_IDLE);
    assign fail_o        = r_q.fail && (r_q.st == S_IDLE);
    assign fail_blk_o    = r_q.fail_blk;
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
    parameter int NBLK    = 4,
    parameter int ERS_MAX = 4000,
    localparam int RUN_W  = $clog2(ERS_MAX + 2) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            swe_o,
    input logic [NBLK-1:0] blk_sel_o,
    input logic            esu_o,
    input logic            ers_o,
    input logic            ev_o,
    input logic            wdt_arm_o,
    input logic            flash_we_o,
    input logic            flash_re_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            fail_o
);
    logic [RUN_W-1:0] ers_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      ers_run_q <= '0;
        else if (ers_o)  ers_run_q <= (ers_run_q == '1) ? ers_run_q : ers_run_q + 1'b1;
        else             ers_run_q <= '0;
    end

    // R3
    ers_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_o |-> (esu_o && swe_o && wdt_arm_o && (blk_sel_o != '0)));

    // R4
    ers_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_run_q <= RUN_W'(ERS_MAX));

    // R5
    esu_after_ers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(esu_o) |-> (!ers_o && $past(!ers_o)));

    // R5
    ev_not_in_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o |-> (!esu_o && !ers_o && !wdt_arm_o));

    // R6
    access_in_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_we_o || flash_re_o) |-> (ev_o && !esu_o && !(flash_we_o && flash_re_o)));

    // R9
    one_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_sel_o));

    // R2
    busy_ends_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o ^ fail_o));

    // R10
    flag_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> (!busy_o && !swe_o && !(done_o && fail_o)));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(.NBLK(NBLK), .ERS_MAX(ERS_MAX)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .swe_o      (swe_o),
    .blk_sel_o  (blk_sel_o),
    .esu_o      (esu_o),
    .ers_o      (ers_o),
    .ev_o       (ev_o),
    .wdt_arm_o  (wdt_arm_o),
    .flash_we_o (flash_we_o),
    .flash_re_o (flash_re_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
    localparam int NBLK = 4, ADDR_W = 3, CNT_W = 16, DATA_W = 16, TRY_W = 4, ERS_MAX = 20;
    localparam int BAD_ADDR = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0;
    logic [NBLK-1:0] mask = '0;
    logic [CNT_W-1:0] tx = 3, ty = 4, tz = 6, ta = 2, tb = 3, tg = 2, te = 2, th = 3, tt = 2;
    logic [TRY_W-1:0] ntries = 3;
    logic [DATA_W-1:0] rdata;
    logic swe, esu, ers, ev, wdt, we, re, busy, done, fail;
    logic [NBLK-1:0] bsel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [1:0] fblk;

    flash_erase_seq #(.NBLK(NBLK), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
                      .TRY_W(TRY_W), .ERS_MAX(ERS_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_mask_i(mask),
        .t_swe_i(tx), .t_esu_i(ty), .t_erase_i(tz), .t_esu_off_i(ta), .t_wdt_clr_i(tb),
        .t_ev_on_i(tg), .t_rd_i(te), .t_ev_off_i(th), .t_swe_off_i(tt),
        .max_tries_i(ntries), .flash_rdata_i(rdata),
        .swe_o(swe), .blk_sel_o(bsel), .esu_o(esu), .ers_o(ers), .ev_o(ev), .wdt_arm_o(wdt),
        .flash_we_o(we), .flash_re_o(re), .flash_addr_o(addr), .flash_wdata_o(wdata),
        .busy_o(busy), .done_o(done), .fail_o(fail), .fail_blk_o(fblk)
    );

    int errors = 0, checks = 0;
    logic [15:0] need = '0;

    // monitor state, written only by the monitor process
    int cyc = 0, pulses = 0, viol = 0, ordv = 0, last_blk = -1, len_run = 0, last_len = 0;
    int bpulses [NBLK];
    int t_swe_r, t_esu_r, t_ers_f, t_esu_f, t_ev_r, t_we, t_ev_f, t_swe_f;
    int exp_addr = 0, we_addr = 0;
    bit first_we = 0;
    logic [NBLK-1:0] run_mask = '0;
    logic p_swe = 0, p_esu = 0, p_ers = 0, p_ev = 0, p_wdt = 0, p_flag = 0;
    logic [NBLK-1:0] p_bsel = '0;

    function automatic int blk_idx(input logic [NBLK-1:0] s);
        int k = 0;
        for (int i = 0; i < NBLK; i++) if (s[i]) k = i;
        return k;
    endfunction

    initial for (int i = 0; i < NBLK; i++) bpulses[i] = 0;

    // flash model: word BAD_ADDR stays unerased until the block has had enough pulses
    always_comb begin
        int b;
        b = blk_idx(bsel);
        rdata = (bpulses[b] >= int'(need[b*4 +: 4]) || int'(addr) != BAD_ADDR) ? 16'hFFFF : 16'h7FFF;
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (start && !busy && |mask) begin
                pulses = 0; viol = 0; ordv = 0; last_blk = -1; run_mask = mask;
                for (int i = 0; i < NBLK; i++) bpulses[i] = 0;
            end
            if (swe && !p_swe) t_swe_r = cyc;
            if (bsel != '0 && p_bsel == '0) begin
                if (cyc - t_swe_r < int'(tx)) viol++;
                if (blk_idx(bsel) <= last_blk || !run_mask[blk_idx(bsel)]) ordv++;
                last_blk = blk_idx(bsel);
            end
            if (esu && !p_esu) t_esu_r = cyc;
            if (ers && !p_ers) begin
                if (cyc - t_esu_r < int'(ty)) viol++;
                pulses++; bpulses[blk_idx(bsel)]++; len_run = 0;
            end
            if (ers) len_run++;
            if (!ers && p_ers) begin last_len = len_run; t_ers_f = cyc; end
            if (!esu && p_esu) begin
                if (cyc - t_ers_f < int'(ta)) viol++;
                t_esu_f = cyc;
            end
            if (!wdt && p_wdt && (cyc - t_esu_f < int'(tb))) viol++;
            if (ev && !p_ev) begin t_ev_r = cyc; exp_addr = 0; first_we = 1; end
            if (we) begin
                if (first_we && (cyc - t_ev_r < int'(tg))) viol++;
                if (wdata != 16'hFFFF) viol++;
                first_we = 0; we_addr = int'(addr); t_we = cyc;
            end
            if (re) begin
                if (cyc - t_we < int'(te)) viol++;
                if (int'(addr) != we_addr || int'(addr) != exp_addr) viol++;
                if (rdata == 16'hFFFF) exp_addr++;
            end
            if (!ev && p_ev) t_ev_f = cyc;
            if (!swe && p_swe) begin
                if (cyc - t_ev_f < int'(th)) viol++;
                t_swe_f = cyc;
            end
            if ((done || fail) && !p_flag && (cyc - t_swe_f < int'(tt))) viol++;
        end
        p_swe = swe; p_esu = esu; p_ers = ers; p_ev = ev; p_wdt = wdt; p_bsel = bsel;
        p_flag = done || fail;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [NBLK-1:0] m);
        @(posedge clk); #1; start = 1'b1; mask = m;
        @(posedge clk); #1; start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [3:0]  m;
        logic [15:0] nd;
        logic [3:0]  nt;
        logic        ef;
        logic [1:0]  eb;
        logic [7:0]  ep;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'b0001, 16'h0001, 4'd3, 1'b0, 2'd0, 8'd1},
        '{4'b1010, 16'h3020, 4'd3, 1'b0, 2'd0, 8'd5},
        '{4'b0110, 16'h0410, 4'd3, 1'b1, 2'd2, 8'd4},
        '{4'b1111, 16'h0000, 4'd1, 1'b0, 2'd0, 8'd4},
        '{4'b0101, 16'h0002, 4'd1, 1'b1, 2'd0, 8'd1},
        '{4'b1000, 16'h4000, 4'd4, 1'b0, 2'd0, 8'd4}
    };

    task automatic erase_len_case(input int z, input int exp);
        tz = CNT_W'(z); need = 16'h0001; ntries = 3;
        do_start(4'b0001);
        wait_idle();
        chk(last_len == exp, "R4 erase pulse length", last_len, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 state during reset
        chk({swe, bsel, esu, ers, ev, wdt, we, re, busy, done, fail} == '0, "R1 outputs in reset",
            int'({swe, esu, ers, ev, busy}), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({swe, bsel, esu, ers, ev, wdt, we, re, busy, done, fail} == '0, "R1 outputs after reset",
            int'({swe, esu, ers, ev, busy}), 0);

        for (int v = 0; v < 6; v++) begin
            need = VEC[v].nd; ntries = VEC[v].nt;
            do_start(VEC[v].m);
            @(negedge clk);
            chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
            wait_idle();
            chk(done == !VEC[v].ef, "R10 done flag", int'(done), int'(!VEC[v].ef));
            chk(fail == VEC[v].ef, "R8 fail flag", int'(fail), int'(VEC[v].ef));
            if (VEC[v].ef) chk(fblk == VEC[v].eb, "R8 failing block index", int'(fblk), int'(VEC[v].eb));
            chk(pulses == int'(VEC[v].ep), "R7 R8 erase pulse count", pulses, int'(VEC[v].ep));
            chk(viol == 0, "R3 R5 R6 R10 strobe order and waits", viol, 0);
            chk(ordv == 0, "R9 block order", ordv, 0);
        end

        // R10 flag held, then cleared by the next accepted start
        tz = 6; need = 16'h0001; ntries = 3;
        do_start(4'b0001);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R10 done held", int'(done), 1);

        // R11 zero mask ignored
        do_start(4'b0000);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && swe == 1'b0, "R11 zero mask no run", int'(busy), 0);
        chk(done == 1'b1, "R11 done kept", int'(done), 1);

        // R2 start while busy is ignored
        do_start(4'b0001);
        @(negedge clk);
        chk(done == 1'b0, "R10 done cleared on start", int'(done), 0);
        repeat (10) @(posedge clk);
        #1; start = 1'b1; mask = 4'b1111;
        @(posedge clk); #1; start = 1'b0;
        wait_idle();
        chk(done == 1'b1 && pulses == 1, "R2 busy start ignored pulses", pulses, 1);
        chk(ordv == 0 && last_blk == 0, "R2 R9 only block 0 touched", last_blk, 0);

        // R4 pulse length and ceiling
        erase_len_case(50, ERS_MAX);
        erase_len_case(7, 7);
        erase_len_case(0, 1);
        chk(viol == 0, "R3 R5 waits with zero pulse", viol, 0);

        // R3 R5 R6 R10 zero waits still keep order
        tx = 0; ty = 0; ta = 0; tb = 0; tg = 0; te = 0; th = 0; tt = 0; tz = 1;
        need = 16'h0200; ntries = 2;
        do_start(4'b0100);
        wait_idle();
        chk(done == 1'b1 && pulses == 2, "R7 retry with zero waits", pulses, 2);
        chk(viol == 0, "R6 address pairing zero waits", viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule